// File: doc/BRIEF.md
# Two-Class Coherence Message Link

This block sits on one point-to-point link that carries cache-coherence traffic from one sender to one receiver. Each message is a bundle of sender id, receiver id, command code, a class bit, a line address and a data word. The class bit decides which of two internal queues takes the message. Replies, which carry results, go in the urgent class. Requests go in the ordinary class. The two queues feed one shared output bus that uses valid/ready handshaking.

Each class keeps its own arrival order. When both queues hold work, the urgent class always wins the output. Each class also has its own input ready. Because of this, a backed-up request queue can never stop a reply from being accepted or delivered. Only the request stream feels that backpressure. This is what keeps a coherence protocol free of deadlock when the home node stops taking new requests but still has to see replies.

The 4-bit command encoding puts requests at codes 0 to 4 and replies at codes 8 to 12. Bit 3 of the command is therefore set exactly for replies. The sender sets the class bit to match, and the link routes on the class bit alone.

Top module: `prio_msg_link`

## Requirements
- R1: After a cycle with `rst_n` low, both queues are empty, `out_valid` is 0, and both input readies are 1.
- R2: An accepted message with `in_prio`=1 enters the urgent queue, and one with `in_prio`=0 enters the ordinary queue. The matching empty flag is low in the cycle after acceptance.
- R3: A delivered message shows every field (sender, receiver, command, class, address, data) exactly as it was accepted.
- R4: Within one class, messages leave in the order they were accepted.
- R5: Whenever the urgent queue holds a message, the output presents the urgent queue's oldest message.
- R6: `in_hi_ready` depends only on the urgent queue's occupancy. A full ordinary queue neither lowers it nor delays delivery of urgent messages.
- R7: A message leaves its queue only in a cycle where `out_valid` and `out_ready` are both 1. While `out_ready` is low, no message is lost.
- R8: A queue holding `DEPTH` messages raises its full flag and drops its ready. A message of that class offered while the queue is full is not accepted and never appears at the output.
- R9: `out_valid` is 1 exactly when at least one queue is non-empty.
- R10: An accept and a delivery on the same queue in the same cycle leave its occupancy unchanged and keep both messages in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input message offered |
| in_src | input | SRC_W | Sender id |
| in_dst | input | DST_W | Receiver id |
| in_cmd | input | 4 | Command code (bit 3 set for replies) |
| in_prio | input | 1 | Class bit: 1 urgent, 0 ordinary |
| in_addr | input | ADDR_W | Line address |
| in_data | input | DATA_W | Data word |
| in_hi_ready | output | 1 | Urgent queue can accept |
| in_lo_ready | output | 1 | Ordinary queue can accept |
| out_valid | output | 1 | Output message valid |
| out_ready | input | 1 | Receiver takes the output message |
| out_src | output | SRC_W | Sender id |
| out_dst | output | DST_W | Receiver id |
| out_cmd | output | 4 | Command code |
| out_prio | output | 1 | Class bit |
| out_addr | output | ADDR_W | Line address |
| out_data | output | DATA_W | Data word |
| hi_full | output | 1 | Urgent queue full |
| hi_empty | output | 1 | Urgent queue empty |
| lo_full | output | 1 | Ordinary queue full |
| lo_empty | output | 1 | Ordinary queue empty |

## Verification
The bench builds the link with `DEPTH`=3 and default field widths. A depth that is not a power of two makes the read and write pointers wrap through an explicit compare rather than by natural overflow. It also makes both queues fill within a few cycles, so refused offers while full show up often. One phase fills the ordinary queue and then streams only urgent traffic against a free receiver, which shows replies passing a stuck request queue. A long mixed phase with random receiver stalls then exercises same-cycle accept and delivery, and urgent arrivals that preempt a waiting ordinary message.

// File: rtl/coh_link_pkg.sv
// Package: shared constants and command codes for the two-class link.
// Assumes a 4-bit command field whose top bit marks a reply.
package coh_link_pkg;

    localparam int CMD_W       = 4;
    localparam int NUM_CLASSES = 2;
    localparam int CLASS_LO    = 0;
    localparam int CLASS_HI    = 1;

    typedef enum logic [CMD_W-1:0] {
        CMD_SHARE_ASK   = 4'h0,
        CMD_OWN_ASK     = 4'h1,
        CMD_WBACK_ASK   = 4'h2,
        CMD_KILL_ASK    = 4'h3,
        CMD_PURGE_ASK   = 4'h4,
        CMD_SHARE_GRANT = 4'h8,
        CMD_OWN_GRANT   = 4'h9,
        CMD_WBACK_DONE  = 4'hA,
        CMD_KILL_DONE   = 4'hB,
        CMD_PURGE_DONE  = 4'hC
    } coh_cmd_e;

    // Reports whether a command code belongs to the reply (urgent) class.
    function automatic logic cmd_is_reply(input logic [CMD_W-1:0] code);
        return code[CMD_W-1];
    endfunction

endpackage

// File: rtl/msg_fifo.sv
// Module: msg_fifo
// Show-ahead FIFO of DEPTH entries of WIDTH bits. The head is read
// combinationally from storage. Flags come from a registered count.
// Assumes the caller never pushes when full and never pops when empty.
// Any DEPTH >= 2 works, power of two or not.
module msg_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Advances a pointer by one, wrapping after the last slot.
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    // Stores an incoming word in the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // Moves the write pointer on each push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (push) begin
            wr_ptr <= step(wr_ptr);
        end
    end

    // Moves the read pointer on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= step(rd_ptr);
        end
    end

    // Tracks occupancy; a push and a pop together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Presents the oldest word and the occupancy flags.
    always_comb begin
        head  = slots[rd_ptr];
        full  = (count == FULL_CNT);
        empty = (count == '0);
    end

endmodule

// File: rtl/prio_select.sv
// Module: prio_select
// Strict-priority picker for the shared output. The urgent queue wins
// whenever it is non-empty. A pop goes only to the queue whose head is
// on the bus, and only when the receiver is ready.
// Assumes both heads are valid whenever their empty flags are low.
module prio_select #(
    parameter int WIDTH = 8
) (
    input  logic             hi_empty,
    input  logic             lo_empty,
    input  logic [WIDTH-1:0] hi_head,
    input  logic [WIDTH-1:0] lo_head,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_msg,
    output logic             pop_hi,
    output logic             pop_lo
);

    logic take_hi;

    // Chooses the source queue and derives the handshake pops.
    always_comb begin
        take_hi   = !hi_empty;
        out_valid = !hi_empty || !lo_empty;
        out_msg   = take_hi ? hi_head : lo_head;
        pop_hi    = out_ready && take_hi;
        pop_lo    = out_ready && !take_hi && !lo_empty;
    end

endmodule

// File: rtl/prio_msg_link.sv
// Module: prio_msg_link
// Two-class coherence message link. Incoming messages are steered by
// their class bit into one of two queues. A strict-priority picker then
// drives one shared valid/ready output. Each class has its own input
// ready, so backpressure on one class never touches the other.
// Assumes the sender sets in_prio to match the reply/request nature of
// in_cmd, and holds nothing against a lowered ready.
module prio_msg_link
    import coh_link_pkg::*;
#(
    parameter int SRC_W  = 3,
    parameter int DST_W  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [DST_W-1:0]  in_dst,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic              in_prio,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_hi_ready,
    output logic              in_lo_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SRC_W-1:0]  out_src,
    output logic [DST_W-1:0]  out_dst,
    output logic [CMD_W-1:0]  out_cmd,
    output logic              out_prio,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              hi_full,
    output logic              hi_empty,
    output logic              lo_full,
    output logic              lo_empty
);

    localparam int MSG_W = SRC_W + DST_W + CMD_W + 1 + ADDR_W + DATA_W;

    logic [MSG_W-1:0] in_msg;
    logic [MSG_W-1:0] sel_msg;
    logic [MSG_W-1:0] q_head  [NUM_CLASSES];
    logic             q_push  [NUM_CLASSES];
    logic             q_pop   [NUM_CLASSES];
    logic             q_full  [NUM_CLASSES];
    logic             q_empty [NUM_CLASSES];

    // Packs the input fields into one queue word.
    always_comb begin
        in_msg = {in_src, in_dst, in_cmd, in_prio, in_addr, in_data};
    end

    // One queue per class; each accepts only its own class and only when not full.
    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_class
        localparam logic CLASS_BIT = (g == CLASS_HI);

        // Steers a valid input of this class into the queue if there is room.
        always_comb begin
            q_push[g] = in_valid && (in_prio == CLASS_BIT) && !q_full[g];
        end

        msg_fifo #(
            .WIDTH (MSG_W),
            .DEPTH (DEPTH)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (q_push[g]),
            .push_data (in_msg),
            .pop       (q_pop[g]),
            .head      (q_head[g]),
            .full      (q_full[g]),
            .empty     (q_empty[g])
        );
    end

    logic pop_hi_w;
    logic pop_lo_w;

    prio_select #(
        .WIDTH (MSG_W)
    ) u_select (
        .hi_empty  (q_empty[CLASS_HI]),
        .lo_empty  (q_empty[CLASS_LO]),
        .hi_head   (q_head[CLASS_HI]),
        .lo_head   (q_head[CLASS_LO]),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_msg   (sel_msg),
        .pop_hi    (pop_hi_w),
        .pop_lo    (pop_lo_w)
    );

    // Routes the picker's pops back to the class queues.
    always_comb begin
        q_pop[CLASS_HI] = pop_hi_w;
        q_pop[CLASS_LO] = pop_lo_w;
    end

    // Unpacks the chosen word and exposes per-class readies and flags.
    always_comb begin
        {out_src, out_dst, out_cmd, out_prio, out_addr, out_data} = sel_msg;
        in_hi_ready = !q_full[CLASS_HI];
        in_lo_ready = !q_full[CLASS_LO];
        hi_full     = q_full[CLASS_HI];
        hi_empty    = q_empty[CLASS_HI];
        lo_full     = q_full[CLASS_LO];
        lo_empty    = q_empty[CLASS_LO];
    end

endmodule

// File: rtl/prio_msg_link_chk.sv
// Module: prio_msg_link_chk
// Property checker for prio_msg_link, attached through bind below.
// Observes only the top module's ports.
module prio_msg_link_chk #(
    parameter int SRC_W  = 3,
    parameter int DST_W  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_prio,
    input logic              in_hi_ready,
    input logic              in_lo_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SRC_W-1:0]  out_src,
    input logic [DST_W-1:0]  out_dst,
    input logic [3:0]        out_cmd,
    input logic              out_prio,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic              hi_full,
    input logic              hi_empty,
    input logic              lo_full,
    input logic              lo_empty
);

    AST_RESET_CLEAR: assert property (@(posedge clk) $past(!rst_n) && rst_n |-> hi_empty && lo_empty && !out_valid) else $error("reset state"); // R1
    AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !hi_empty |-> out_prio) else $error("urgent not first"); // R5
    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) out_valid == !(hi_empty && lo_empty)) else $error("valid mismatch"); // R9
    AST_HI_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n) lo_full && !hi_full |-> in_hi_ready) else $error("urgent blocked"); // R6
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready && !(in_valid && in_prio) |=> out_valid && $stable({out_src, out_dst, out_cmd, out_prio, out_addr, out_data})) else $error("output changed under stall"); // R7
    AST_HI_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) hi_full && !(out_valid && out_ready) |=> hi_full) else $error("urgent full lost"); // R8
    AST_LO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) lo_full && !(out_valid && out_ready && hi_empty) |=> lo_full && !in_lo_ready) else $error("ordinary full lost"); // R8

endmodule

bind prio_msg_link prio_msg_link_chk #(
    .SRC_W  (SRC_W),
    .DST_W  (DST_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_prio     (in_prio),
    .in_hi_ready (in_hi_ready),
    .in_lo_ready (in_lo_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_src     (out_src),
    .out_dst     (out_dst),
    .out_cmd     (out_cmd),
    .out_prio    (out_prio),
    .out_addr    (out_addr),
    .out_data    (out_data),
    .hi_full     (hi_full),
    .hi_empty    (hi_empty),
    .lo_full     (lo_full),
    .lo_empty    (lo_empty)
);

// File: tb/prio_msg_link_test.sv
// Bench for prio_msg_link: a behavioural two-queue model compared every cycle.
module prio_msg_link_test;

    localparam int CLK_PERIOD = 10;
    localparam int SRC_W  = 3;
    localparam int DST_W  = 3;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 3;
    localparam int MSG_W  = SRC_W + DST_W + 4 + 1 + ADDR_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [SRC_W-1:0]  in_src = '0;
    logic [DST_W-1:0]  in_dst = '0;
    logic [3:0]        in_cmd = '0;
    logic              in_prio = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_hi_ready, in_lo_ready, out_valid;
    logic              out_ready = 1'b0;
    logic [SRC_W-1:0]  out_src;
    logic [DST_W-1:0]  out_dst;
    logic [3:0]        out_cmd;
    logic              out_prio;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic              hi_full, hi_empty, lo_full, lo_empty;

    int n_run  = 0;
    int n_fail = 0;
    logic [MSG_W-1:0] hq[$];
    logic [MSG_W-1:0] lq[$];
    int seq = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_msg_link #(
        .SRC_W(SRC_W), .DST_W(DST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst),
        .in_cmd(in_cmd), .in_prio(in_prio), .in_addr(in_addr), .in_data(in_data),
        .in_hi_ready(in_hi_ready), .in_lo_ready(in_lo_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_src(out_src), .out_dst(out_dst), .out_cmd(out_cmd),
        .out_prio(out_prio), .out_addr(out_addr), .out_data(out_data),
        .hi_full(hi_full), .hi_empty(hi_empty), .lo_full(lo_full), .lo_empty(lo_empty)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compares every port against the model state (called at a negedge).
    task automatic compare_all();
        logic [MSG_W-1:0] exp_msg;
        chk("R9 out_valid", out_valid, (hq.size() + lq.size()) > 0);
        chk("R2 hi_empty", hi_empty, hq.size() == 0);
        chk("R2 lo_empty", lo_empty, lq.size() == 0);
        chk("R8 hi_full", hi_full, hq.size() == DEPTH);
        chk("R8 lo_full", lo_full, lq.size() == DEPTH);
        chk("R6 in_hi_ready", in_hi_ready, hq.size() < DEPTH);
        chk("R8 in_lo_ready", in_lo_ready, lq.size() < DEPTH);
        if (hq.size() + lq.size() > 0) begin
            exp_msg = (hq.size() > 0) ? hq[0] : lq[0];
            chk("R3 R4 R5 out message",
                {out_src, out_dst, out_cmd, out_prio, out_addr, out_data}, exp_msg);
        end
    endtask

    // Drives one cycle of stimulus and advances the model to match the next edge.
    task automatic step(input int vpct, input int hipct, input int rdypct);
        int hs, ls;
        logic hi_cls;
        compare_all();
        hs = hq.size();
        ls = lq.size();
        in_valid  = ($urandom % 100) < vpct;
        hi_cls    = ($urandom % 100) < hipct;
        in_prio   = hi_cls;
        in_cmd    = hi_cls ? 4'(8 + $urandom % 5) : 4'($urandom % 5);
        in_src    = SRC_W'($urandom);
        in_dst    = DST_W'($urandom);
        in_addr   = ADDR_W'($urandom);
        in_data   = DATA_W'(seq);
        seq++;
        out_ready = ($urandom % 100) < rdypct;
        // R7: model removes a message only on a completed handshake.
        if (out_ready && hs > 0) void'(hq.pop_front());
        else if (out_ready && ls > 0) void'(lq.pop_front());
        // R8: an offer to a full queue is dropped; R10 push and pop may coincide.
        if (in_valid && hi_cls && hs < DEPTH)
            hq.push_back({in_src, in_dst, in_cmd, in_prio, in_addr, in_data});
        if (in_valid && !hi_cls && ls < DEPTH)
            lq.push_back({in_src, in_dst, in_cmd, in_prio, in_addr, in_data});
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: state after reset, readies high, nothing valid.
        chk("R1 out_valid", out_valid, 1'b0);
        chk("R1 hi_empty", hi_empty, 1'b1);
        chk("R1 lo_empty", lo_empty, 1'b1);
        chk("R1 in_hi_ready", in_hi_ready, 1'b1);
        chk("R1 in_lo_ready", in_lo_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        // R8/R7: receiver stalled, mixed offers fill both queues and get refused.
        for (int i = 0; i < 30; i++) step(80, 50, 0);
        // Drain.
        for (int i = 0; i < 10; i++) step(0, 0, 100);
        // R6: fill the ordinary queue, then stream urgent traffic past it.
        for (int i = 0; i < 10; i++) step(100, 0, 0);
        for (int i = 0; i < 40; i++) step(100, 100, 100);
        // R10: continuous traffic with a ready receiver, same-cycle push and pop.
        for (int i = 0; i < 200; i++) step(100, 30, 100);
        // Mixed random phase with stalls (R4 R5 R7 preemption).
        for (int i = 0; i < 3000; i++) step(60, 40, 55);
        for (int i = 0; i < 10; i++) step(0, 0, 100);
        compare_all();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule